// File: doc/BRIEF.md
# Pin I/O Register Controller

This block is the register side of a 32-pin general-purpose I/O unit. A 32-bit register port lets software set, per pin, a bypass bit, a direction bit, an output enable, an output level, an interrupt mask, an interrupt kind (level or edge), an interrupt polarity and an any-edge flag. The block drives the output pins from these registers. It samples the input pins through a two-flop synchroniser into a readable input-value register. It forwards the configuration and the sampled inputs to a separate event detector. That detector returns a per-pin status vector, which the block makes readable and ORs into one interrupt line.

The register port is a plain single-cycle interface, with no valid/ready pair and no back-pressure. A write takes effect at the rising edge on which `wr_en` is high. Read data is combinational from the presented address, so it is valid in the same cycle.

Only 32-bit accesses exist. The window is 0x400 bytes wide, and an address whose two low bits are not zero is treated as unmapped. The interrupt mask cannot be written directly. It changes only through two dedicated addresses: one that unmasks bits and one that masks them.

Top module: `gpio_regctl`

## Requirements
- R1: After reset every register reads 0, except the mask at 0x14, which reads 0xFFFFFFFF (1 = masked). In this state `pin_oe` and `pin_out` are 0.
- R2: The following registers read back exactly the full 32-bit value last written: bypass at 0x00, direction at 0x04, output enable at 0x08, output value at 0x0C, interrupt kind at 0x24, interrupt polarity at 0x28 and any-edge at 0x2C.
- R3: A write to 0x18 clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R4: A write to 0x1C sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R5: Writes to 0x10 (input value), 0x14 (mask) and 0x20 (status) change nothing. The addresses 0x18 and 0x1C read as 0.
- R6: Offsets 0x30 to 0x3FC, and any address with bit 1 or bit 0 set, read as 0, and a write to them changes no register.
- R7: A level on `pin_in` appears at 0x10 and on `cfg_in_value` after exactly two rising edges.
- R8: `pin_oe[i]` is 1 and `pin_out[i]` equals output-value bit i exactly when bypass bit i is 0, direction bit i is 0 (0 = output, 1 = input) and output-enable bit i is 1. This follows in the same cycle as the register update.
- R9: While pin i is not driven, `pin_oe[i]` is 0 and `pin_out[i]` keeps the level it last drove (0 if it has never been driven).
- R10: `irq` is 1 exactly when `det_status` is nonzero, and 0x20 reads `det_status`.
- R11: The `cfg_*` outputs carry the current bypass, direction, mask, interrupt kind, polarity and any-edge register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 10 | Byte address within the register window |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| pin_in | input | 32 | Asynchronous input pin levels |
| pin_out | output | 32 | Output pin levels |
| pin_oe | output | 32 | Per-pin drive enable for the pad |
| det_status | input | 32 | Per-pin interrupt status from the event detector |
| irq | output | 1 | Combined interrupt |
| cfg_bypass | output | 32 | Bypass register to detector |
| cfg_dir | output | 32 | Direction register to detector |
| cfg_mask | output | 32 | Mask register to detector |
| cfg_kind | output | 32 | Interrupt kind register to detector |
| cfg_pol | output | 32 | Interrupt polarity register to detector |
| cfg_anyedge | output | 32 | Any-edge register to detector |
| cfg_in_value | output | 32 | Synchronised input levels to detector |

## Verification
The hardest state to reach from the ports is a pin that holds a level it drove earlier, while output value and enable now say something else. Reaching it needs an ordered series of writes. The stimulus first drives a byte pattern. It then turns some of those pins into inputs or bypassed pins and rewrites the output value. Finally it checks that only the still-driven pins follow while the others keep their old levels. Misaligned and out-of-range writes are placed right after known register contents, so that any corruption shows up in the read-back.

// File: rtl/gpio_regctl_pkg.sv
package gpio_regctl_pkg;
  // word indices (byte offset / 4); software depends on these
  localparam int WI_BYPASS  = 0;
  localparam int WI_DIR     = 1;
  localparam int WI_OE      = 2;
  localparam int WI_OVAL    = 3;
  localparam int WI_INVAL   = 4;
  localparam int WI_MASK    = 5;
  localparam int WI_UNMASK  = 6;
  localparam int WI_DOMASK  = 7;
  localparam int WI_STATUS  = 8;
  localparam int WI_KIND    = 9;
  localparam int WI_POL     = 10;
  localparam int WI_ANYEDGE = 11;

  // plain read/write registers, in storage-slot order
  localparam int NPLAIN = 7;
  localparam int PLAIN_IDX [NPLAIN] = '{WI_BYPASS, WI_DIR, WI_OE, WI_OVAL,
                                        WI_KIND, WI_POL, WI_ANYEDGE};
  localparam int SLOT_BYPASS  = 0;
  localparam int SLOT_DIR     = 1;
  localparam int SLOT_OE      = 2;
  localparam int SLOT_OVAL    = 3;
  localparam int SLOT_KIND    = 4;
  localparam int SLOT_POL     = 5;
  localparam int SLOT_ANYEDGE = 6;
endpackage

// File: rtl/gpio_regctl_sync2.sv
module gpio_regctl_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= async_i;
      hold_q <= meta_q;
    end
  end

  assign sync_o = hold_q;

  AST_SYNC_SECOND_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o == $past(meta_q)); // R7
endmodule

// File: rtl/gpio_regctl_regfile.sv
module gpio_regctl_regfile
  import gpio_regctl_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [NPINS-1:0]  in_value,
  input  logic [NPINS-1:0]  det_status,
  output logic [NPINS-1:0]  bypass_o,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  oe_o,
  output logic [NPINS-1:0]  oval_o,
  output logic [NPINS-1:0]  mask_o,
  output logic [NPINS-1:0]  kind_o,
  output logic [NPINS-1:0]  pol_o,
  output logic [NPINS-1:0]  anyedge_o
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam int NREG   = WI_ANYEDGE + 1;

  logic              aligned;
  logic [WIDX_W-1:0] widx;
  logic [NREG-1:0]   sel;
  logic              mapped;
  logic [NPINS-1:0]  wd;

  logic [NPLAIN-1:0][NPINS-1:0] plain_q;
  logic [NPINS-1:0]             mask_q;

  assign aligned = (addr[1:0] == 2'b00);
  assign widx    = addr[ADDR_W-1:2];
  assign wd      = wr_data[NPINS-1:0];

  always_comb begin
    sel = '0;
    for (int k = 0; k < NREG; k++) begin
      sel[k] = aligned && (widx == WIDX_W'(k));
    end
  end
  assign mapped = |sel;

  for (genvar p = 0; p < NPLAIN; p++) begin : g_plain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        plain_q[p] <= '0;
      end else if (wr_en && sel[PLAIN_IDX[p]]) begin
        plain_q[p] <= wd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (wr_en && sel[WI_UNMASK]) begin
      mask_q <= mask_q & ~wd;
    end else if (wr_en && sel[WI_DOMASK]) begin
      mask_q <= mask_q | wd;
    end
  end

  always_comb begin
    logic [NPINS-1:0] r;
    r = '0;
    if (aligned) begin
      case (widx)
        WIDX_W'(WI_BYPASS):  r = plain_q[SLOT_BYPASS];
        WIDX_W'(WI_DIR):     r = plain_q[SLOT_DIR];
        WIDX_W'(WI_OE):      r = plain_q[SLOT_OE];
        WIDX_W'(WI_OVAL):    r = plain_q[SLOT_OVAL];
        WIDX_W'(WI_INVAL):   r = in_value;
        WIDX_W'(WI_MASK):    r = mask_q;
        WIDX_W'(WI_STATUS):  r = det_status;
        WIDX_W'(WI_KIND):    r = plain_q[SLOT_KIND];
        WIDX_W'(WI_POL):     r = plain_q[SLOT_POL];
        WIDX_W'(WI_ANYEDGE): r = plain_q[SLOT_ANYEDGE];
        default:             r = '0;
      endcase
    end
    rd_data = '0;
    rd_data[NPINS-1:0] = r;
  end

  assign bypass_o  = plain_q[SLOT_BYPASS];
  assign dir_o     = plain_q[SLOT_DIR];
  assign oe_o      = plain_q[SLOT_OE];
  assign oval_o    = plain_q[SLOT_OVAL];
  assign kind_o    = plain_q[SLOT_KIND];
  assign pol_o     = plain_q[SLOT_POL];
  assign anyedge_o = plain_q[SLOT_ANYEDGE];
  assign mask_o    = mask_q;

  AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel[WI_UNMASK]) |=> ((mask_o & $past(wd)) == '0)); // R3
  AST_DOMASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel[WI_DOMASK]) |=> ((mask_o & $past(wd)) == $past(wd))); // R4
  AST_READONLY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel[WI_MASK] || sel[WI_INVAL] || sel[WI_STATUS]))
      |=> ($stable(mask_o) && $stable(plain_q))); // R5
  AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> ($stable(plain_q) && $stable(mask_o))); // R6
endmodule

// File: rtl/gpio_regctl_outgate.sv
module gpio_regctl_outgate #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] bypass_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] oe_i,
  input  logic [NPINS-1:0] oval_i,
  output logic [NPINS-1:0] pin_out_o,
  output logic [NPINS-1:0] pin_oe_o
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic drive;
    logic held_q;

    assign drive = !bypass_i[i] && !dir_i[i] && oe_i[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held_q <= 1'b0;
      end else if (drive) begin
        held_q <= oval_i[i];
      end
    end

    assign pin_oe_o[i]  = drive;
    assign pin_out_o[i] = drive ? oval_i[i] : held_q;

    AST_UNDRIVEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe_o[i] |-> $stable(pin_out_o[i])); // R9
  end
endmodule

// File: rtl/gpio_regctl.sv
module gpio_regctl #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic [NPINS-1:0]  det_status,
  output logic              irq,
  output logic [NPINS-1:0]  cfg_bypass,
  output logic [NPINS-1:0]  cfg_dir,
  output logic [NPINS-1:0]  cfg_mask,
  output logic [NPINS-1:0]  cfg_kind,
  output logic [NPINS-1:0]  cfg_pol,
  output logic [NPINS-1:0]  cfg_anyedge,
  output logic [NPINS-1:0]  cfg_in_value
);
  logic [NPINS-1:0] oe_reg;
  logic [NPINS-1:0] oval_reg;

  gpio_regctl_sync2 #(.W(NPINS)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_in),
    .sync_o  (cfg_in_value)
  );

  gpio_regctl_regfile #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .in_value   (cfg_in_value),
    .det_status (det_status),
    .bypass_o   (cfg_bypass),
    .dir_o      (cfg_dir),
    .oe_o       (oe_reg),
    .oval_o     (oval_reg),
    .mask_o     (cfg_mask),
    .kind_o     (cfg_kind),
    .pol_o      (cfg_pol),
    .anyedge_o  (cfg_anyedge)
  );

  gpio_regctl_outgate #(.NPINS(NPINS)) i_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .bypass_i  (cfg_bypass),
    .dir_i     (cfg_dir),
    .oe_i      (oe_reg),
    .oval_i    (oval_reg),
    .pin_out_o (pin_out),
    .pin_oe_o  (pin_oe)
  );

  assign irq = |det_status;

  AST_DRIVEN_HAS_OUTPUT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & (cfg_dir | cfg_bypass)) == '0)); // R8
endmodule

// File: tb/test_gpio_regctl.sv
module test_gpio_regctl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [9:0]  waddr;
    logic [31:0] wdata;
    logic [9:0]  raddr;
    logic [31:0] rexp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{10'h000, 32'hA5A5_0F0F, 10'h000, 32'hA5A5_0F0F, 8'd2},  // R2 bypass
    '{10'h004, 32'hFFFF_0000, 10'h004, 32'hFFFF_0000, 8'd2},  // R2 direction
    '{10'h008, 32'h1234_5678, 10'h008, 32'h1234_5678, 8'd2},  // R2 output enable
    '{10'h00C, 32'hCAFE_F00D, 10'h00C, 32'hCAFE_F00D, 8'd2},  // R2 output value
    '{10'h024, 32'h0F0F_0F0F, 10'h024, 32'h0F0F_0F0F, 8'd2},  // R2 kind
    '{10'h028, 32'h8000_0001, 10'h028, 32'h8000_0001, 8'd2},  // R2 polarity
    '{10'h02C, 32'hDEAD_BEEF, 10'h02C, 32'hDEAD_BEEF, 8'd2},  // R2 any-edge
    '{10'h018, 32'h0000_00FF, 10'h014, 32'hFFFF_FF00, 8'd3},  // R3 unmask
    '{10'h01C, 32'h0000_000F, 10'h014, 32'hFFFF_FF0F, 8'd4},  // R4 mask
    '{10'h018, 32'hFFFF_FFFF, 10'h014, 32'h0000_0000, 8'd3},  // R3 unmask all
    '{10'h014, 32'hFFFF_FFFF, 10'h014, 32'h0000_0000, 8'd5},  // R5 mask read-only
    '{10'h010, 32'hFFFF_FFFF, 10'h010, 32'h0000_0000, 8'd5},  // R5 input read-only
    '{10'h018, 32'h0000_0000, 10'h018, 32'h0000_0000, 8'd5},  // R5 write-only reads 0
    '{10'h030, 32'hFFFF_FFFF, 10'h030, 32'h0000_0000, 8'd6},  // R6 unmapped
    '{10'h001, 32'h1111_1111, 10'h000, 32'hA5A5_0F0F, 8'd6},  // R6 misaligned write
    '{10'h3FC, 32'h0000_0001, 10'h3FC, 32'h0000_0000, 8'd6}   // R6 top of window
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [31:0] det_status = '0;
  logic        irq;
  logic [31:0] cfg_bypass, cfg_dir, cfg_mask, cfg_kind, cfg_pol, cfg_anyedge, cfg_in_value;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_regctl i_gpio_regctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .det_status(det_status), .irq(irq), .cfg_bypass(cfg_bypass), .cfg_dir(cfg_dir),
    .cfg_mask(cfg_mask), .cfg_kind(cfg_kind), .cfg_pol(cfg_pol),
    .cfg_anyedge(cfg_anyedge), .cfg_in_value(cfg_in_value)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1 d = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_reset_state();
    // R1: all registers 0, mask all ones, pins undriven
    for (int w = 0; w < 12; w++) begin
      if (w == 5) continue;
      rd(10'(w * 4), rv);
      chk("R1 register reset", rv, 32'h0);
    end
    rd(10'h014, rv);
    chk("R1 mask reset", rv, 32'hFFFF_FFFF);
    chk("R1 pin_oe reset", pin_oe, 32'h0);
    chk("R1 pin_out reset", pin_out, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    check_reset_state();

    for (int v = 0; v < NVEC; v++) begin
      wr(VECS[v].waddr, VECS[v].wdata);
      rd(VECS[v].raddr, rv);
      chk($sformatf("R%0d vector %0d", VECS[v].req, v), rv, VECS[v].rexp);
    end

    // R7: two-edge input latency
    @(negedge clk);
    pin_in = 32'h0000_8001;
    addr = 10'h010;
    @(posedge clk); #1;
    chk("R7 after one edge", rd_data, 32'h0);
    @(posedge clk); #1;
    chk("R7 after two edges", rd_data, 32'h0000_8001);
    chk("R7 cfg_in_value", cfg_in_value, 32'h0000_8001);

    // R10: combined interrupt and status read
    @(negedge clk);
    det_status = 32'h0; addr = 10'h020;
    #1 chk("R10 irq low", {31'b0, irq}, 32'h0);
    det_status = 32'h0000_0400;
    #1 chk("R10 irq high", {31'b0, irq}, 32'h1);
    chk("R10 status read", rd_data, 32'h0000_0400);
    det_status = 32'h0;
    #1 chk("R10 irq clears", {31'b0, irq}, 32'h0);

    // fresh start for output-path sequence
    pin_in = 32'h0;
    do_reset();
    check_reset_state();

    wr(10'h00C, 32'h0000_00AA);
    #1 chk("R9 oe off pin_oe", pin_oe, 32'h0);
    chk("R9 oe off pin_out", pin_out, 32'h0);
    wr(10'h008, 32'h0000_00FF);
    #1 chk("R8 driven pin_oe", pin_oe, 32'h0000_00FF);
    chk("R8 driven pin_out", pin_out, 32'h0000_00AA);
    wr(10'h004, 32'h0000_00F0);
    #1 chk("R8 inputs released", pin_oe, 32'h0000_000F);
    chk("R9 levels held", pin_out, 32'h0000_00AA);
    wr(10'h00C, 32'h0000_0055);
    #1 chk("R9 held upper nibble", pin_out, 32'h0000_00A5);
    wr(10'h000, 32'h0000_0001);
    #1 chk("R8 bypass releases", pin_oe, 32'h0000_000E);
    chk("R9 bypass holds", pin_out, 32'h0000_00A5);
    wr(10'h00C, 32'h0000_0000);
    #1 chk("R9 mixed hold", pin_out, 32'h0000_00A1);

    // R11: configuration outputs
    wr(10'h024, 32'h3333_0000);
    wr(10'h028, 32'h0000_CCCC);
    wr(10'h02C, 32'h8000_0008);
    wr(10'h018, 32'h0000_FFFF);
    #1 chk("R11 cfg_bypass", cfg_bypass, 32'h0000_0001);
    chk("R11 cfg_dir", cfg_dir, 32'h0000_00F0);
    chk("R11 cfg_kind", cfg_kind, 32'h3333_0000);
    chk("R11 cfg_pol", cfg_pol, 32'h0000_CCCC);
    chk("R11 cfg_anyedge", cfg_anyedge, 32'h8000_0008);
    chk("R11 cfg_mask", cfg_mask, 32'hFFFF_0000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule